// File: doc/BRIEF.md
# Pipelined hit-coincidence trigger matrix

This block turns one clock's worth of per-channel hit bits from three or four detector planes into a 32-bit trigger word. The word is meant for a second-level decision unit. The first registered stage builds every allowed multi-plane coincidence as the AND of one hit bit from each plane. A coincidence may take a different channel index on each plane, which is how a slanted track is expressed. The later stages fold those coincidence bits through a tree of 4-input ORs until one bit is left per trigger-word position.

The combination table is fixed at elaboration and computed from the parameters. Coincidence `j` pairs channel `a = j % 32` on plane A with channel `(a+s)%32` on plane B, channel `(a+2s)%32` on plane C and, in four-plane mode, channel `(a+3s)%32` on plane D. Here `s = j / 32` is the track slope, and its range is 0 to 63.

Each stage is one clock long, and a new word is accepted on every clock. A qualifier bit travels alongside the data, so the output carries its own valid flag.

Top module: `trig_coinc_matrix`

## Requirements
- R1: With the defaults, the result for the inputs sampled at one rising edge appears on `trig_out` after the fifth rising edge counted from that one, so the latency is NLVL+2 edges.
- R2: `out_vld` equals the `in_vld` value that was sampled together with the word now on `trig_out`.
- R3: A word sampled while `in_vld` is 0 is treated as all-zero hits, so its `trig_out` is 0.
- R4: Bit o of `trig_out` is 1 exactly when some channel a (0..31) and some slope s in {2o, 2o+1} give `hit_a[a]`, `hit_b[(a+s)%32]` and `hit_c[(a+2s)%32]` all set. In four-plane mode, `hit_d[(a+3s)%32]` must also be set.
- R5: Only hits sampled at the same edge combine: hits of one track split across two consecutive cycles produce no trigger bit.
- R6: With USE_P3 = 1 a coincidence also needs its plane-D hit. With USE_P3 = 0, `hit_d` has no effect on `trig_out`.
- R7: A different word may be presented on every clock with no stall, and each word yields its own result in order.
- R8: While `rst` is high at a rising edge, `trig_out` is 0 and `out_vld` is 0 after that edge.
- R9: A valid word with every hit of every used plane set drives all 32 bits of `trig_out` to 1.
- R10: A valid word in which any used plane has no hit at all gives `trig_out` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Stage clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Qualifies the hit words of this cycle |
| hit_a | input | 32 | Hit bits of plane A |
| hit_b | input | 32 | Hit bits of plane B |
| hit_c | input | 32 | Hit bits of plane C |
| hit_d | input | 32 | Hit bits of plane D, used only in four-plane mode |
| trig_out | output | 32 | Trigger word, one bit per pair of slopes |
| out_vld | output | 1 | Qualifier of `trig_out` |

## Verification
A three-plane instance and a four-plane instance are driven with the same stimulus.

An exhaustive sweep places one single-hit track at every channel and every slope. This shows whether each output bit collects exactly its own two slopes, and whether slopes that wrap past 32 land on the right bit. The same tracks are also sent with the plane-D hit removed, which separates the two modes. Other patterns cover:
- tracks whose hits are split across two cycles, which tell same-cycle coincidence apart from accumulation;
- full and empty planes;
- words held back by a low qualifier;
- long runs of dense and sparse random words on every clock, which expose any mixing between neighbouring pipeline slots.

// File: rtl/trig_coinc_matrix.sv
module trig_coinc_matrix #(
  parameter int CH     = 32,
  parameter int NLVL   = 3,
  parameter int OUT_W  = 32,
  parameter bit USE_P3 = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [CH-1:0]    hit_a,
  input  logic [CH-1:0]    hit_b,
  input  logic [CH-1:0]    hit_c,
  input  logic [CH-1:0]    hit_d,
  output logic [OUT_W-1:0] trig_out,
  output logic             out_vld
);
  localparam int FAN = 4 ** NLVL;
  localparam int NCO = OUT_W * FAN;
  localparam int LAT = NLVL + 2;

  function automatic int lvl_off(input int k);
    int o;
    o = 0;
    for (int i = 0; i < k; i++) o += NCO >> (2 * i);
    return o;
  endfunction

  localparam int TOT = lvl_off(NLVL + 1);

  logic [CH-1:0]  a_q, b_q, c_q, d_q;
  logic [NCO-1:0] co_d, co_q;
  logic [LAT-1:0] vld_q;
  logic [TOT-1:0] tree;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      b_q   <= '0;
      c_q   <= '0;
      d_q   <= '0;
      co_q  <= '0;
      vld_q <= '0;
    end else begin
      a_q   <= in_vld ? hit_a : '0;
      b_q   <= in_vld ? hit_b : '0;
      c_q   <= in_vld ? hit_c : '0;
      d_q   <= USE_P3 ? hit_d : '1;
      co_q  <= co_d;
      vld_q <= {vld_q[LAT-2:0], in_vld};
    end
  end

  for (genvar j = 0; j < NCO; j++) begin : g_co
    localparam int S  = j / CH;
    localparam int AI = j % CH;
    localparam int BI = (AI + S) % CH;
    localparam int CI = (AI + 2 * S) % CH;
    localparam int DI = (AI + 3 * S) % CH;
    assign co_d[j] = a_q[AI] & b_q[BI] & c_q[CI] & d_q[DI];
  end

  assign tree[NCO-1:0] = co_q;

  for (genvar l = 0; l < NLVL; l++) begin : g_or
    localparam int W     = NCO >> (2 * (l + 1));
    localparam int IN_O  = lvl_off(l);
    localparam int OUT_O = lvl_off(l + 1);
    logic [W-1:0] r_q;
    always_ff @(posedge clk) begin
      if (rst) r_q <= '0;
      else for (int g = 0; g < W; g++) r_q[g] <= |tree[IN_O + 4*g +: 4];
    end
    assign tree[OUT_O +: W] = r_q;
  end

  assign trig_out = tree[lvl_off(NLVL) +: OUT_W];
  assign out_vld  = vld_q[LAT-1];
endmodule

// File: rtl/trig_coinc_matrix_chk.sv
module trig_coinc_matrix_chk #(
  parameter int CH     = 32,
  parameter int NLVL   = 3,
  parameter int OUT_W  = 32,
  parameter bit USE_P3 = 1'b0
) (
  input logic             clk,
  input logic             rst,
  input logic             in_vld,
  input logic [CH-1:0]    hit_a,
  input logic [CH-1:0]    hit_b,
  input logic [CH-1:0]    hit_c,
  input logic [CH-1:0]    hit_d,
  input logic [OUT_W-1:0] trig_out,
  input logic             out_vld
);
  localparam int LAT = NLVL + 2;
  localparam int AW  = $clog2(LAT + 1) + 1;

  logic [LAT-1:0] v_sh, full_sh, zero_sh;
  logic [AW-1:0]  age;
  logic           full_now, zero_now;

  assign full_now = in_vld & (&hit_a) & (&hit_b) & (&hit_c) & (!USE_P3 | (&hit_d));
  assign zero_now = in_vld & ((hit_a == '0) | (hit_b == '0) | (hit_c == '0) |
                              (USE_P3 & (hit_d == '0)));

  always_ff @(posedge clk) begin
    if (rst) begin
      v_sh <= '0; full_sh <= '0; zero_sh <= '0; age <= '0;
    end else begin
      v_sh    <= {v_sh[LAT-2:0], in_vld};
      full_sh <= {full_sh[LAT-2:0], full_now};
      zero_sh <= {zero_sh[LAT-2:0], zero_now};
      if (age < AW'(LAT)) age <= age + 1'b1;
    end
  end

  AST_VLD_DELAY: assert property (@(posedge clk) disable iff (rst)
    (age >= AW'(LAT)) |-> (out_vld == v_sh[LAT-1]));                        // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> (trig_out == '0));                                        // R3
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (trig_out == '0 && !out_vld));                                 // R8
  AST_FULL_FIRE: assert property (@(posedge clk) disable iff (rst)
    (age >= AW'(LAT) && full_sh[LAT-1]) |-> (trig_out == '1));             // R9
  AST_EMPTY_PLANE: assert property (@(posedge clk) disable iff (rst)
    (age >= AW'(LAT) && zero_sh[LAT-1]) |-> (trig_out == '0));             // R10
endmodule

bind trig_coinc_matrix trig_coinc_matrix_chk #(
  .CH(CH), .NLVL(NLVL), .OUT_W(OUT_W), .USE_P3(USE_P3)
) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld),
  .hit_a(hit_a), .hit_b(hit_b), .hit_c(hit_c), .hit_d(hit_d),
  .trig_out(trig_out), .out_vld(out_vld)
);

// File: tb/trig_coinc_matrix_test.sv
`timescale 1ns/100ps
module trig_coinc_matrix_test;
  localparam int LAT = 5;
  localparam int NMAX = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic [31:0] hit_a = '0, hit_b = '0, hit_c = '0, hit_d = '0;
  logic [31:0] trig3, trig4;
  logic vld3, vld4;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [31:0] exp3 [NMAX];
  logic [31:0] exp4 [NMAX];
  logic        expv [NMAX];
  string       tagm [NMAX];

  always #2.5 clk = ~clk;

  trig_coinc_matrix #(.USE_P3(1'b0)) uut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .hit_a(hit_a), .hit_b(hit_b),
    .hit_c(hit_c), .hit_d(hit_d), .trig_out(trig3), .out_vld(vld3));

  trig_coinc_matrix #(.USE_P3(1'b1)) uut_four (
    .clk(clk), .rst(rst), .in_vld(in_vld), .hit_a(hit_a), .hit_b(hit_b),
    .hit_c(hit_c), .hit_d(hit_d), .trig_out(trig4), .out_vld(vld4));

  function automatic logic [31:0] model(input logic [31:0] a, b, c, d,
                                        input bit four, input bit v);
    logic [31:0] r;
    r = '0;
    if (!v) return r;
    for (int o = 0; o < 32; o++)
      for (int k = 0; k < 2; k++)
        for (int ch = 0; ch < 32; ch++) begin
          int s;
          s = 2 * o + k;
          if (a[ch] && b[(ch + s) % 32] && c[(ch + 2 * s) % 32] &&
              (!four || d[(ch + 3 * s) % 32]))
            r[o] = 1'b1;
        end
    return r;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // R1: the word driven at cycle n is compared at the negedge of cycle n+LAT
  // R7: a new word is driven on every clock
  task automatic drive(input logic [31:0] a, b, c, d, input bit v, input string tag);
    @(negedge clk);
    if (cyc >= LAT) begin
      check(tagm[cyc-LAT], "R1 three-plane word", trig3, exp3[cyc-LAT]);
      check(tagm[cyc-LAT], "R1 four-plane word", trig4, exp4[cyc-LAT]);
      check("R2", "valid flag", {31'b0, vld3}, {31'b0, expv[cyc-LAT]});
      check("R2", "valid flag four-plane", {31'b0, vld4}, {31'b0, expv[cyc-LAT]});
    end
    exp3[cyc] = model(a, b, c, d, 1'b0, v);
    exp4[cyc] = model(a, b, c, d, 1'b1, v);
    expv[cyc] = v;
    tagm[cyc] = tag;
    hit_a = a; hit_b = b; hit_c = c; hit_d = d; in_vld = v;
    cyc++;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog expired: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8", "reset word", trig3, '0);
    check("R8", "reset word four-plane", trig4, '0);
    check("R8", "reset valid", {31'b0, vld3 | vld4}, '0);
    rst = 1'b0;

    drive('1, '1, '1, '1, 1'b1, "R9");
    drive('1, '1, '1, '1, 1'b0, "R3");
    drive('0, '1, '1, '1, 1'b1, "R10");
    drive('1, '1, '0, '1, 1'b1, "R10");
    drive('1, '1, '1, '0, 1'b1, "R10");
    drive('1, '1, '1, '1, 1'b1, "R9");

    // R4: every single-track position, slope and channel
    for (int o = 0; o < 32; o++)
      for (int k = 0; k < 2; k++)
        for (int ch = 0; ch < 32; ch++) begin
          int s;
          s = 2 * o + k;
          drive(32'h1 << ch, 32'h1 << ((ch + s) % 32), 32'h1 << ((ch + 2 * s) % 32),
                32'h1 << ((ch + 3 * s) % 32), 1'b1, "R4");
        end

    // R6: tracks without their plane-D hit, or with unrelated plane-D hits
    for (int o = 0; o < 32; o++) begin
      int s;
      s = 2 * o + (o & 1);
      drive(32'h1 << o, 32'h1 << ((o + s) % 32), 32'h1 << ((o + 2 * s) % 32),
            '0, 1'b1, "R6");
      drive(32'h1 << o, 32'h1 << ((o + s) % 32), 32'h1 << ((o + 2 * s) % 32),
            $urandom, 1'b1, "R6");
    end

    // R5: the same track split over two cycles
    for (int o = 0; o < 32; o++) begin
      int s;
      s = 2 * o;
      drive(32'h1 << o, '0, '0, '1, 1'b1, "R5");
      drive('0, 32'h1 << ((o + s) % 32), 32'h1 << ((o + 2 * s) % 32), '1, 1'b1, "R5");
    end

    // R3: valid tracks held back by the qualifier
    for (int o = 0; o < 16; o++)
      drive($urandom, $urandom, $urandom, $urandom, 1'b0, "R3");

    // R7: back-to-back sparse and dense random words
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb, rc, rd;
      ra = $urandom & $urandom & $urandom;
      rb = $urandom & $urandom & $urandom;
      rc = $urandom & $urandom & $urandom;
      rd = $urandom & $urandom;
      if (i % 3 == 0) begin ra = $urandom; rb = $urandom; rc = $urandom; rd = $urandom; end
      drive(ra, rb, rc, rd, ($urandom % 5) != 0, "R7");
    end

    for (int i = 0; i < LAT + 1; i++) drive('0, '0, '0, '0, 1'b0, "R3");
    summary();
    $finish;
  end
endmodule